// File: doc/BRIEF.md
# SDRAM Refresh Urgency Scheduler

This block decides when an SDRAM controller spends time on auto-refresh. A reload value, held in a rate register that the controller can rewrite at any time, sets the refresh interval. A down-counter runs from that value to zero and then starts over. Each time it reaches zero, one refresh is owed. The owed refreshes collect in a saturating 4-bit backlog.

The backlog is graded into four urgency tiers by its two upper bits. Each tier has its own rule for how far a refresh may push aside the controller's own traffic. The rules depend on four inputs: requests pending, read requests pending, any bank open, and an access in progress. Once the chosen rule allows a refresh, the block runs a two-command sequence on a command port with a valid/ready handshake. It first issues a precharge-all command and then an auto-refresh command. After each accepted command it waits a fixed number of cycles, which covers the precharge and refresh recovery times.

The command port back-pressures in the usual way. While `cmd_valid` is high and `cmd_ready` is low, the command and its opcode are held unchanged. A command counts as accepted only in a cycle where both `cmd_valid` and `cmd_ready` are high. `busy` tells the access engine to keep off the memory. Refresh generation cannot be switched off. The backlog keeps growing even when no memory answers the command port.

Top module: `sdram_refresh_sched`

## Requirements
- R1: The interval counter loads the rate value at reset and at every rate write. Without a write, the backlog grows by one every RATE+1 cycles. A rate write restarts the count and cancels an expiry that would have fallen on the same cycle.
- R2: The backlog grows by one per interval expiry and saturates at 15. It grows even when the command port never accepts a command.
- R3: The backlog shrinks by one when an auto-refresh command is accepted. If an expiry and an acceptance fall on the same cycle, the backlog keeps its value.
- R4: A refresh sequence issues `cmd_op`=0 (precharge-all) and then `cmd_op`=1 (auto-refresh). `cmd_valid` and `cmd_op` are held while `cmd_ready` is low. After each accepted command, `cmd_valid` stays low for exactly WAIT_CYC cycles.
- R5: `busy` goes high in the cycle after a refresh is decided. It stays high until the last wait of the sequence has ended.
- R6: With a backlog of 0, no refresh is issued. With a backlog of 1 to 3, a refresh starts only when no request is pending, no bank is open and no access is in progress.
- R7: With a backlog of 4 to 7, a refresh starts when no request is pending and no access is in progress, even if banks are open.
- R8: With a backlog of 8 to 11, a refresh starts when no access is in progress and no read request is pending, even if write requests are pending.
- R9: From a backlog of 12 or more, `busy` rises and stays high without a gap. Refresh sequences then run back to back whenever no access is in progress, whatever requests are pending. This continues until the backlog has fallen to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_wr | input | 1 | Write strobe for the refresh rate register |
| rate_val | input | RATE_W | New refresh reload value |
| req_pending | input | 1 | Any read or write request waiting |
| rd_pending | input | 1 | A read request waiting |
| bank_open | input | 1 | At least one bank has an open row |
| access_active | input | 1 | An access is currently in progress |
| cmd_valid | output | 1 | Refresh command offered |
| cmd_ready | input | 1 | Command accepted by the sequencer downstream |
| cmd_op | output | 1 | 0 = precharge-all, 1 = auto-refresh |
| busy | output | 1 | Access engine must hold off |
| owed | output | BL_W | Current refresh backlog |

## Verification
The bench sweeps every backlog level from 0 to 15 against all 16 combinations of the four traffic inputs. A design that decoded a tier boundary wrongly would start a refresh one level too early or too late, or would let a read request delay a refresh it is not allowed to delay. The interval is checked cycle by cycle for several small rates. The bench also writes the rate on the very cycle of an expiry: a design that did not cancel that expiry would show an extra owed refresh. One run lines an expiry up with an auto-refresh acceptance, where a naive counter would step by one instead of holding. The drain test starts at a backlog of 13 with reads pending. A design that released `busy` between sequences, or stopped at the wrong level, would give a refresh count other than six or a final backlog other than 7.

// File: rtl/sdram_rfsh_pkg.sv
package sdram_rfsh_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRE,
    SQ_PRE_WAIT,
    SQ_REF,
    SQ_REF_WAIT
  } seq_state_t;

  localparam logic CMD_PRECHARGE_ALL = 1'b0;
  localparam logic CMD_AUTO_REFRESH  = 1'b1;

  // Urgency tiers: the two upper bits of the backlog.
  localparam logic [1:0] TIER_LOW  = 2'b00;
  localparam logic [1:0] TIER_MID  = 2'b01;
  localparam logic [1:0] TIER_HIGH = 2'b10;
  localparam logic [1:0] TIER_CRIT = 2'b11;

  function automatic logic refresh_allowed(
    input logic [1:0] tier,
    input logic       nonzero,
    input logic       draining,
    input logic       req,
    input logic       rd,
    input logic       bank,
    input logic       act
  );
    logic ok;
    if (draining || tier == TIER_CRIT) begin
      ok = !act;
    end else begin
      case (tier)
        TIER_HIGH: ok = !act && !rd;
        TIER_MID:  ok = !act && !req;
        default:   ok = nonzero && !act && !req && !bank;
      endcase
    end
    return ok;
  endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
  parameter int          RATE_W     = 13,
  parameter logic [RATE_W-1:0] RESET_RATE = RATE_W'(1560)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_val,
  output logic              expire
);

  logic [RATE_W-1:0] rate_q;
  logic [RATE_W-1:0] cnt_q;

  // A write restarts the interval and cancels a coincident expiry.
  assign expire = (cnt_q == '0) && !rate_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q <= RESET_RATE;
      cnt_q  <= RESET_RATE;
    end else if (rate_wr) begin
      rate_q <= rate_val;
      cnt_q  <= rate_val;
    end else if (cnt_q == '0) begin
      cnt_q <= rate_q;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/rfsh_backlog.sv
module rfsh_backlog #(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            inc,
  input  logic            dec,
  output logic [BL_W-1:0] owed,
  output logic [1:0]      tier,
  output logic            draining
);
  import sdram_rfsh_pkg::*;

  localparam logic [BL_W-1:0] BL_MAX = {BL_W{1'b1}};

  logic [BL_W-1:0] owed_q;
  logic            drain_q;

  assign owed     = owed_q;
  assign tier     = owed_q[BL_W-1 -: 2];
  assign draining = drain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owed_q  <= '0;
      drain_q <= 1'b0;
    end else begin
      case ({inc, dec})
        2'b10:   if (owed_q != BL_MAX) owed_q <= owed_q + 1'b1;
        2'b01:   if (owed_q != '0)     owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
      // Enter drain at the critical tier, leave once back in the lower half.
      if (tier == TIER_CRIT)        drain_q <= 1'b1;
      else if (!owed_q[BL_W-1])     drain_q <= 1'b0;
    end
  end

endmodule

// File: rtl/rfsh_cmd_seq.sv
module rfsh_cmd_seq #(
  parameter int WAIT_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic cmd_ready,
  output logic cmd_valid,
  output logic cmd_op,
  output logic ref_done,
  output logic seq_idle
);
  import sdram_rfsh_pkg::*;

  localparam int WAIT_W = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(WAIT_CYC - 1);

  seq_state_t       state_q, state_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic             accept;

  assign cmd_valid = (state_q == SQ_PRE) || (state_q == SQ_REF);
  assign cmd_op    = (state_q == SQ_REF) ? CMD_AUTO_REFRESH : CMD_PRECHARGE_ALL;
  assign accept    = cmd_valid && cmd_ready;
  assign ref_done  = accept && (state_q == SQ_REF);
  assign seq_idle  = (state_q == SQ_IDLE);

  always_comb begin
    state_d = state_q;
    wcnt_d  = wcnt_q;
    case (state_q)
      SQ_IDLE: if (start) state_d = SQ_PRE;
      SQ_PRE: if (accept) begin
        state_d = SQ_PRE_WAIT;
        wcnt_d  = WAIT_LOAD;
      end
      SQ_PRE_WAIT: begin
        if (wcnt_q == '0) state_d = SQ_REF;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      SQ_REF: if (accept) begin
        state_d = SQ_REF_WAIT;
        wcnt_d  = WAIT_LOAD;
      end
      SQ_REF_WAIT: begin
        if (wcnt_q == '0) state_d = SQ_IDLE;
        else              wcnt_d  = wcnt_q - 1'b1;
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      wcnt_q  <= wcnt_d;
    end
  end

endmodule

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int                RATE_W     = 13,
  parameter logic [RATE_W-1:0] RESET_RATE = RATE_W'(1560),
  parameter int                BL_W       = 4,
  parameter int                WAIT_CYC   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rate_wr,
  input  logic [RATE_W-1:0] rate_val,
  input  logic              req_pending,
  input  logic              rd_pending,
  input  logic              bank_open,
  input  logic              access_active,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_op,
  output logic              busy,
  output logic [BL_W-1:0]   owed
);
  import sdram_rfsh_pkg::*;

  logic       expire;
  logic       ref_done;
  logic       seq_idle;
  logic       draining;
  logic [1:0] tier;
  logic       start;

  rfsh_interval_timer #(
    .RATE_W    (RATE_W),
    .RESET_RATE(RESET_RATE)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate_wr (rate_wr),
    .rate_val(rate_val),
    .expire  (expire)
  );

  rfsh_backlog #(
    .BL_W(BL_W)
  ) u_backlog (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc     (expire),
    .dec     (ref_done),
    .owed    (owed),
    .tier    (tier),
    .draining(draining)
  );

  assign start = seq_idle && refresh_allowed(tier, (owed != '0), draining,
                                             req_pending, rd_pending,
                                             bank_open, access_active);

  rfsh_cmd_seq #(
    .WAIT_CYC(WAIT_CYC)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .ref_done (ref_done),
    .seq_idle (seq_idle)
  );

  assign busy = !seq_idle || draining;

endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
  parameter int BL_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic            cmd_ready,
  input logic            cmd_op,
  input logic            busy,
  input logic [BL_W-1:0] owed
);

  logic [BL_W:0] owed_x;
  assign owed_x = {1'b0, owed};

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op)); // R4

  AST_OWED_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_x == $past(owed_x)) || (owed_x == $past(owed_x) + 1'b1) ||
    ($past(owed_x) == owed_x + 1'b1)); // R2

  AST_DEC_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
    (owed_x < $past(owed_x)) |-> $past(cmd_valid && cmd_ready && cmd_op)); // R3

  AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> busy); // R5

  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && owed == '0 |=> !cmd_valid); // R6

  AST_CRIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    owed[BL_W-1 -: 2] == 2'b11 |=> busy); // R9

endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(.BL_W(BL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_op   (cmd_op),
  .busy     (busy),
  .owed     (owed)
);

// File: tb/sdram_refresh_sched_tb.sv
module sdram_refresh_sched_tb;

  localparam int RATE_W = 13;
  localparam int BL_W   = 4;
  localparam int WAITC  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_wr = 1'b0;
  logic [RATE_W-1:0] rate_val = '0;
  logic req_pending = 1'b0, rd_pending = 1'b0, bank_open = 1'b0, access_active = 1'b0;
  logic cmd_ready = 1'b0;
  logic cmd_valid, cmd_op, busy;
  logic [BL_W-1:0] owed;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  sdram_refresh_sched #(
    .RATE_W(RATE_W), .RESET_RATE(13'd9), .BL_W(BL_W), .WAIT_CYC(WAITC)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_wr(rate_wr), .rate_val(rate_val),
    .req_pending(req_pending), .rd_pending(rd_pending), .bank_open(bank_open),
    .access_active(access_active), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .busy(busy), .owed(owed)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_traffic(input bit rq, input bit rd, input bit bk, input bit ac);
    req_pending = rq; rd_pending = rd; bank_open = bk; access_active = ac;
  endtask

  // Leaves the bench at the negedge after the first edge out of reset (E0).
  task automatic do_reset(input int rate);
    rst_n = 1'b0; rate_wr = 1'b1; rate_val = RATE_W'(rate);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  // Builds a backlog of t with traffic blocked, then freezes accrual.
  task automatic set_owed(input int t);
    set_traffic(1, 1, 1, 1);
    cmd_ready = 1'b0;
    do_reset(0);
    while (int'(owed) != t) @(negedge clk);
    rate_wr = 1'b1; rate_val = 13'd8000;
    @(negedge clk);
    rate_wr = 1'b0;
  endtask

  function automatic bit expect_issue(input int t, input bit rq, input bit rd, input bit bk, input bit ac);
    if (t == 0)  return 1'b0;
    if (t <= 3)  return !rq && !bk && !ac;
    if (t <= 7)  return !rq && !ac;
    if (t <= 11) return !ac && !rd;
    return !ac;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // Reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(owed == 0 && !busy && !cmd_valid, "reset state", int'(owed), 0);

    // R1 / R2: interval period and saturation for small rates
    set_traffic(1, 1, 1, 1);
    for (int r = 0; r <= 5; r++) begin
      do_reset(r);
      check(owed == 0, "R1 k=0", int'(owed), 0);
      for (int k = 1; k <= 40; k++) begin
        int e;
        @(negedge clk);
        e = k / (r + 1);
        if (e > 15) e = 15;
        check(int'(owed) == e, $sformatf("R2 rate=%0d k=%0d", r, k), int'(owed), e);
      end
    end

    // R1: rewrite mid-interval restarts the count
    do_reset(5);
    repeat (3) @(negedge clk);
    rate_wr = 1'b1; rate_val = 13'd5;
    @(negedge clk); rate_wr = 1'b0;
    repeat (5) @(negedge clk);
    check(owed == 0, "R1 restart before expiry", int'(owed), 0);
    @(negedge clk);
    check(owed == 1, "R1 restart expiry", int'(owed), 1);

    // R1: write on the expiry cycle cancels it
    do_reset(2);
    repeat (2) @(negedge clk);
    rate_wr = 1'b1; rate_val = 13'd2;
    @(negedge clk); rate_wr = 1'b0;
    check(owed == 0, "R1 cancel coincident expiry", int'(owed), 0);
    repeat (2) @(negedge clk);
    check(owed == 0, "R1 cancel hold", int'(owed), 0);
    @(negedge clk);
    check(owed == 1, "R1 after cancel", int'(owed), 1);

    // R6..R9: every backlog level against every traffic pattern
    for (int t = 0; t <= 15; t++) begin
      for (int c = 0; c < 16; c++) begin
        bit rq, rd, bk, ac, ex;
        rq = c[3]; rd = c[2]; bk = c[1]; ac = c[0];
        set_owed(t);
        set_traffic(rq, rd, bk, ac);
        @(negedge clk);
        ex = expect_issue(t, rq, rd, bk, ac);
        if (t == 0)
          check(cmd_valid == ex, $sformatf("R6 owed=%0d pat=%0d", t, c), int'(cmd_valid), int'(ex));
        else if (t <= 3)
          check(cmd_valid == ex, $sformatf("R6 owed=%0d pat=%0d", t, c), int'(cmd_valid), int'(ex));
        else if (t <= 7)
          check(cmd_valid == ex, $sformatf("R7 owed=%0d pat=%0d", t, c), int'(cmd_valid), int'(ex));
        else if (t <= 11)
          check(cmd_valid == ex, $sformatf("R8 owed=%0d pat=%0d", t, c), int'(cmd_valid), int'(ex));
        else begin
          check(cmd_valid == ex, $sformatf("R9 owed=%0d pat=%0d", t, c), int'(cmd_valid), int'(ex));
          check(busy == 1'b1, $sformatf("R9 busy owed=%0d pat=%0d", t, c), int'(busy), 1);
        end
        if (ex) check(cmd_op == 1'b0, "R4 first op precharge", int'(cmd_op), 0);
      end
    end

    // R4 / R5: command sequence with back-pressure
    set_owed(1);
    set_traffic(0, 0, 0, 0);
    @(negedge clk);
    check(busy && cmd_valid && cmd_op == 1'b0, "R5 busy with precharge", int'(busy), 1);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(cmd_valid && cmd_op == 1'b0, "R4 precharge held", int'(cmd_valid), 1);
    end
    cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    check(!cmd_valid, "R4 gap 1 after precharge", int'(cmd_valid), 0);
    @(negedge clk);
    check(!cmd_valid, "R4 gap 2 after precharge", int'(cmd_valid), 0);
    @(negedge clk);
    check(cmd_valid && cmd_op == 1'b1, "R4 auto-refresh op", int'(cmd_op), 1);
    check(owed == 1, "R3 no decrement before accept", int'(owed), 1);
    @(negedge clk);
    check(cmd_valid && cmd_op == 1'b1, "R4 auto-refresh held", int'(cmd_valid), 1);
    cmd_ready = 1'b1;
    @(negedge clk); cmd_ready = 1'b0;
    check(owed == 0, "R3 decrement on accept", int'(owed), 0);
    check(busy && !cmd_valid, "R5 busy in wait 1", int'(busy), 1);
    @(negedge clk);
    check(busy && !cmd_valid, "R5 busy in wait 2", int'(busy), 1);
    @(negedge clk);
    check(!busy, "R5 busy released", int'(busy), 0);

    // R9: drain from 13 with reads pending
    begin
      int refs = 0;
      bit gap = 1'b0;
      set_owed(13);
      set_traffic(1, 1, 1, 0);
      cmd_ready = 1'b1;
      for (int i = 0; i < 80; i++) begin
        if (cmd_valid && cmd_ready && cmd_op) refs++;
        @(negedge clk);
        if (owed >= 8 && !busy) gap = 1'b1;
      end
      cmd_ready = 1'b0;
      check(refs == 6, "R9 refresh count in drain", refs, 6);
      check(owed == 7, "R9 drain stop level", int'(owed), 7);
      check(!gap, "R9 busy without gap", int'(gap), 0);
      check(!busy, "R9 release after drain", int'(busy), 0);
    end

    // R3: expiry and acceptance on the same edge
    begin
      int model = 0;
      int hits = 0;
      bit hs;
      set_traffic(0, 0, 0, 0);
      cmd_ready = 1'b1;
      do_reset(4);
      hs = cmd_valid && cmd_ready && cmd_op;
      for (int k = 1; k <= 60; k++) begin
        bit inc;
        @(negedge clk);
        inc = (k % 5 == 0);
        if (inc && hs) hits++;
        else if (inc && model < 15) model++;
        else if (hs && model > 0) model--;
        check(int'(owed) == model, $sformatf("R3 model k=%0d", k), int'(owed), model);
        hs = cmd_valid && cmd_ready && cmd_op;
      end
      check(hits >= 1, "R3 coincidence reached", hits, 1);
      cmd_ready = 1'b0;
    end

    // R2: accrual with no acceptance at all
    set_traffic(0, 0, 0, 0);
    do_reset(1);
    repeat (40) @(negedge clk);
    check(owed == 15, "R2 accrues with port stalled", int'(owed), 15);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule